// File: doc/BRIEF.md
# Maskable Interrupt Cause Register Bank

This block collects single-cycle event pulses from three sources (transmit, receive and miscellaneous) into three 32-bit cause groups. It then folds them into one summary word and a single interrupt line for the host. Each cause bit is sticky and stays set until the host acknowledges it. Each group has a per-bit mask. The host changes that mask only through two write-only ports: one sets the bits written as 1, the other clears the bits written as 1. The host selects, per group and at run time, how cause bits are acknowledged. In read-to-clear mode, reading the cause word clears it. In write-one-to-clear mode, writing a 1 to a bit clears that bit.

Each group drives one summary bit. The bit is set while the group has any cause bit that is set and unmasked. The summary word itself clears when read. A second software mask gates the summary bits before they reach the interrupt output. The interrupt output is a flip-flop. The register bus uses single-cycle write and read strobes. Read data appears on the cycle after the read strobe.

Top module: `irq_cause_bank`

## Requirements
- R1: An event pulse on any bit of a group's event input sets the matching cause bit, and the bit stays set until it is acknowledged. Group g occupies word addresses 8*g to 8*g+7 (transmit g=0, receive g=1, miscellaneous g=2). Its cause word is read at offset 0.
- R2: In write-one-to-clear mode, a write to the cause word (offset 0) clears exactly the cause bits written as 1 and leaves the others set.
- R3: In read-to-clear mode, a read of the cause word returns its value and clears it. A write to the cause word has no effect.
- R4: Writing all ones to the mode word (offset 5) selects read-to-clear. Writing any other value selects write-one-to-clear. The mode word reads back as all ones or all zeros.
- R5: A write to the mask-set port (offset 1) sets every mask bit written as 1 and leaves the other mask bits unchanged. The mask is read at offset 3.
- R6: A write to the mask-clear port (offset 2) clears every mask bit written as 1 and leaves the other mask bits unchanged.
- R7: The masked view (offset 4) reads as the cause word AND NOT the mask.
- R8: Summary bit g (at word address 24) is set one cycle after group g has any set, unmasked cause bit. A read of the summary word clears it, unless a group is still active. Summary bits 3 and above read 0.
- R9: The interrupt output goes high one cycle after any summary bit is set whose software mask bit is 0. The software mask is a read/write word at address 25.
- R10: An event on a cause bit in the same cycle as a write-one or read clear of that bit leaves the bit set.
- R11: After reset, every mask bit and every software mask bit is 1, all cause and summary bits are 0, every group is in write-one-to-clear mode and the interrupt is low.
- R12: A read of an unmapped address returns 0, and a write to one changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| evt_in | input | 96 | Event pulses; group g uses bits 32*g to 32*g+31 |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume the host never raises the write strobe and the read strobe in the same cycle. They also assume that event inputs stay low during reset. Under these assumptions only one decoded access is live per cycle, and the mask-set and mask-clear properties never see both ports written at once. The driver tasks issue one access at a time, each separated by an idle cycle. Pulses arrive only after reset is released. The two collision cases, event against write and event against read, are built by driving both inputs in the same cycle on purpose.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
   // Word offsets inside one cause group
   localparam int OFS_CAUSE = 0;
   localparam int OFS_MSET  = 1;
   localparam int OFS_MCLR  = 2;
   localparam int OFS_MASK  = 3;
   localparam int OFS_MVIEW = 4;
   localparam int OFS_MODE  = 5;

   typedef enum logic {
      CLR_W1C     = 1'b0,
      CLR_ON_READ = 1'b1
   } clr_mode_e;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group
   import irq_cause_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              cause_wr_i,
   input  logic              cause_rd_i,
   input  logic              mset_wr_i,
   input  logic              mclr_wr_i,
   input  logic              mode_wr_i,
   output logic [DATA_W-1:0] cause_o,
   output logic [DATA_W-1:0] mask_o,
   output logic              cor_o,
   output logic              active_o
);
   logic [DATA_W-1:0] cause_q;
   logic [DATA_W-1:0] mask_q;
   clr_mode_e         mode_q;
   logic [DATA_W-1:0] clr_bits;

   always_comb begin
      clr_bits = '0;
      if (mode_q == CLR_W1C && cause_wr_i) clr_bits = wdata_i;
      if (mode_q == CLR_ON_READ && cause_rd_i) clr_bits = cause_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause_q <= '0;
         mask_q  <= '1;
         mode_q  <= CLR_W1C;
      end else begin
         // new events win over a same-cycle clear
         cause_q <= (cause_q & ~clr_bits) | evt_i;
         if (mset_wr_i)      mask_q <= mask_q | wdata_i;
         else if (mclr_wr_i) mask_q <= mask_q & ~wdata_i;
         if (mode_wr_i)
            mode_q <= (wdata_i == '1) ? CLR_ON_READ : CLR_W1C;
      end
   end

   assign cause_o  = cause_q;
   assign mask_o   = mask_q;
   assign cor_o    = (mode_q == CLR_ON_READ);
   assign active_o = |(cause_q & ~mask_q);

   a_r1_evt_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

   a_r10_evt_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & clr_bits)) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));

   a_r2_w1c_partial: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CLR_W1C && cause_wr_i && evt_i == '0)
      |=> (cause_q == ($past(cause_q) & ~$past(wdata_i))));

   a_r3_cor_drains: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CLR_ON_READ && cause_rd_i && evt_i == '0) |=> (cause_q == '0));

   a_r3_cor_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == CLR_ON_READ && cause_wr_i && !cause_rd_i)
      |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

   a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      mset_wr_i |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

   a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (mclr_wr_i && !mset_wr_i) |=> ((mask_q & $past(wdata_i)) == '0));

   a_r4_mode_sel: assert property (@(posedge clk) disable iff (!rst_n)
      mode_wr_i |=> (cor_o == ($past(wdata_i) == '1)));
endmodule

// File: rtl/irq_cause_summary.sv
module irq_cause_summary #(
   parameter int DATA_W = 32,
   parameter int N_GRP  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_GRP-1:0]  active_i,
   input  logic              rd_i,
   input  logic              swm_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] pseudo_o,
   output logic [DATA_W-1:0] swmask_o,
   output logic              irq_o
);
   logic [DATA_W-1:0] pseudo_q;
   logic [DATA_W-1:0] sw_q;
   logic [DATA_W-1:0] act_w;
   logic              irq_q;

   assign act_w = DATA_W'(active_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pseudo_q <= '0;
         sw_q     <= '1;
         irq_q    <= 1'b0;
      end else begin
         pseudo_q <= (rd_i ? '0 : pseudo_q) | act_w;
         if (swm_wr_i) sw_q <= wdata_i;
         irq_q <= |(pseudo_q & ~sw_q);
      end
   end

   assign pseudo_o = pseudo_q;
   assign swmask_o = sw_q;
   assign irq_o    = irq_q;

   a_r8_pseudo_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (|active_i) |=> ((pseudo_q[N_GRP-1:0] & $past(active_i)) == $past(active_i)));

   a_r8_pseudo_cor: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && active_i == '0) |=> (pseudo_q == '0));

   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|(pseudo_q & ~sw_q)) |=> irq_o);

   a_r9_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(pseudo_q & ~sw_q)) |=> !irq_o);
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
   import irq_cause_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int N_GRP     = 3,
   parameter int GRP_SHIFT = 3,
   parameter int ADDR_W    = 5
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   input  logic [N_GRP*DATA_W-1:0] evt_in,
   output logic                    irq
);
   localparam int PSEUDO_ADDR = N_GRP << GRP_SHIFT;
   localparam int SWMASK_ADDR = PSEUDO_ADDR + 1;
   localparam int IDX_W       = ADDR_W - GRP_SHIFT;

   if (DATA_W < N_GRP) begin : g_chk_width
      $error("DATA_W must hold one summary bit per group");
   end
   if (SWMASK_ADDR >= (1 << ADDR_W)) begin : g_chk_addr
      $error("ADDR_W too small for the register map");
   end
   if (GRP_SHIFT < 3) begin : g_chk_stride
      $error("group stride must cover six offsets");
   end

   logic [GRP_SHIFT-1:0] ofs;
   logic [IDX_W-1:0]     grp_idx;
   logic                 hit_pseudo, hit_swm;
   logic [N_GRP-1:0]     grp_hit, w_cause, r_cause, w_mset, w_mclr, w_mode;
   logic [N_GRP-1:0]     active, cor_a;
   logic [DATA_W-1:0]    cause_a [N_GRP];
   logic [DATA_W-1:0]    mask_a  [N_GRP];
   logic [DATA_W-1:0]    pseudo_w, swmask_w, rd_mux, rdata_q;

   assign ofs        = bus_addr[GRP_SHIFT-1:0];
   assign grp_idx    = bus_addr[ADDR_W-1:GRP_SHIFT];
   assign hit_pseudo = (bus_addr == ADDR_W'(PSEUDO_ADDR));
   assign hit_swm    = (bus_addr == ADDR_W'(SWMASK_ADDR));

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      assign grp_hit[g] = (grp_idx == IDX_W'(g));
      assign w_cause[g] = bus_wr & grp_hit[g] & (ofs == GRP_SHIFT'(OFS_CAUSE));
      assign r_cause[g] = bus_rd & grp_hit[g] & (ofs == GRP_SHIFT'(OFS_CAUSE));
      assign w_mset[g]  = bus_wr & grp_hit[g] & (ofs == GRP_SHIFT'(OFS_MSET));
      assign w_mclr[g]  = bus_wr & grp_hit[g] & (ofs == GRP_SHIFT'(OFS_MCLR));
      assign w_mode[g]  = bus_wr & grp_hit[g] & (ofs == GRP_SHIFT'(OFS_MODE));

      irq_cause_group #(.DATA_W(DATA_W)) u_grp (
         .clk        (clk),
         .rst_n      (rst_n),
         .evt_i      (evt_in[g*DATA_W +: DATA_W]),
         .wdata_i    (bus_wdata),
         .cause_wr_i (w_cause[g]),
         .cause_rd_i (r_cause[g]),
         .mset_wr_i  (w_mset[g]),
         .mclr_wr_i  (w_mclr[g]),
         .mode_wr_i  (w_mode[g]),
         .cause_o    (cause_a[g]),
         .mask_o     (mask_a[g]),
         .cor_o      (cor_a[g]),
         .active_o   (active[g])
      );
   end

   irq_cause_summary #(.DATA_W(DATA_W), .N_GRP(N_GRP)) u_sum (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .rd_i     (bus_rd & hit_pseudo),
      .swm_wr_i (bus_wr & hit_swm),
      .wdata_i  (bus_wdata),
      .pseudo_o (pseudo_w),
      .swmask_o (swmask_w),
      .irq_o    (irq)
   );

   always_comb begin
      rd_mux = '0;
      for (int g = 0; g < N_GRP; g++) begin
         if (grp_hit[g]) begin
            case (int'(ofs))
               OFS_CAUSE: rd_mux = cause_a[g];
               OFS_MASK:  rd_mux = mask_a[g];
               OFS_MVIEW: rd_mux = cause_a[g] & ~mask_a[g];
               OFS_MODE:  rd_mux = {DATA_W{cor_a[g]}};
               default:   rd_mux = '0;
            endcase
         end
      end
      if (hit_pseudo) rd_mux = pseudo_w;
      if (hit_swm)    rd_mux = swmask_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

   a_r12_one_write_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({w_cause, w_mset, w_mclr, w_mode, bus_wr & hit_pseudo, bus_wr & hit_swm}));

   a_r11_irq_low_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/irq_cause_bank_bench.sv
`timescale 1ns/1ps
module irq_cause_bank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [95:0] evt_in = '0;
   logic        irq;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2 clk = ~clk;

   irq_cause_bank u_irq_cause_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_in(evt_in), .irq(irq));

   function automatic logic [4:0] ga(int g, int o);
      return 5'(g * 8 + o);
   endfunction

   task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops an expected read value on every read
   always @(posedge clk) begin
      if (bus_rd) begin
         @(negedge clk);
         if (exp_q.size() > 0) chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic do_wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic do_rd(logic [4:0] a, logic [31:0] e, string tag);
      @(negedge clk); bus_rd = 1; bus_addr = a;
      exp_q.push_back(e); tag_q.push_back(tag);
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic pulse(int g, logic [31:0] bits);
      @(negedge clk); evt_in[g*32 +: 32] = bits;
      @(negedge clk); evt_in = '0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      idle(3); rst_n = 1; idle(1);
      // R11 reset state
      chk({31'b0, irq}, 32'h0, "R11 irq");
      do_rd(ga(0,0), 32'h0, "R11 cause");
      do_rd(ga(0,3), 32'hffffffff, "R11 mask");
      do_rd(ga(1,5), 32'h0, "R11 mode");
      do_rd(24, 32'h0, "R11 pseudo");
      do_rd(25, 32'hffffffff, "R11 swmask");
      // R1 latch, R7 view with all masked
      pulse(0, 32'h5);
      do_rd(ga(0,0), 32'h5, "R1 cause latched");
      do_rd(ga(0,0), 32'h5, "R1 cause sticky");
      do_rd(ga(0,4), 32'h0, "R7 view masked");
      do_rd(24, 32'h0, "R8 masked group");
      // R6 unmask bit 0
      do_wr(ga(0,2), 32'h1);
      do_rd(ga(0,3), 32'hfffffffe, "R6 mask clear");
      do_rd(ga(0,4), 32'h1, "R7 view");
      do_rd(24, 32'h1, "R8 pseudo tx");
      chk({31'b0, irq}, 32'h0, "R9 swmask blocks");
      // R8 pseudo clears on read once group inactive
      do_wr(ga(0,1), 32'h1);
      do_rd(24, 32'h1, "R8 pseudo sticky");
      do_rd(24, 32'h0, "R8 pseudo cleared");
      // R9 irq
      do_wr(25, 32'hfffffff8);
      do_wr(ga(0,2), 32'h1);
      idle(3);
      chk({31'b0, irq}, 32'h1, "R9 irq high");
      do_wr(25, 32'hffffffff);
      idle(2);
      chk({31'b0, irq}, 32'h0, "R9 irq masked");
      // R2 write-one-to-clear
      do_wr(ga(0,0), 32'h4);
      do_rd(ga(0,0), 32'h1, "R2 partial clear");
      do_wr(ga(0,0), 32'h1);
      do_rd(ga(0,0), 32'h0, "R2 full clear");
      do_rd(24, 32'h1, "R8 pseudo sticky2");
      do_rd(24, 32'h0, "R8 pseudo cleared2");
      // R4 / R3 read-to-clear on RX
      do_wr(ga(1,5), 32'hffffffff);
      do_rd(ga(1,5), 32'hffffffff, "R4 mode cor");
      pulse(1, 32'h30);
      do_rd(ga(1,0), 32'h30, "R3 cor read");
      do_rd(ga(1,0), 32'h0, "R3 cor cleared");
      pulse(1, 32'h8);
      do_wr(ga(1,0), 32'h8);
      do_rd(ga(1,0), 32'h8, "R3 write ignored");
      do_rd(ga(1,0), 32'h0, "R3 cor cleared2");
      // R4 non-all-ones selects W1C
      do_wr(ga(1,5), 32'h1);
      do_rd(ga(1,5), 32'h0, "R4 mode w1c");
      pulse(1, 32'h2);
      do_rd(ga(1,0), 32'h2, "R4 read no clear");
      do_rd(ga(1,0), 32'h2, "R4 read no clear2");
      do_wr(ga(1,0), 32'h2);
      do_rd(ga(1,0), 32'h0, "R4 w1c works");
      // R10 collision with write-one clear
      pulse(2, 32'h80);
      @(negedge clk); bus_wr = 1; bus_addr = ga(2,0); bus_wdata = 32'h80; evt_in[64 +: 32] = 32'h80;
      @(negedge clk); bus_wr = 0; evt_in = '0;
      do_rd(ga(2,0), 32'h80, "R10 w1c collision");
      do_wr(ga(2,0), 32'h80);
      do_rd(ga(2,0), 32'h0, "R2 misc clear");
      // R10 collision with read clear
      do_wr(ga(2,5), 32'hffffffff);
      pulse(2, 32'h1);
      @(negedge clk); bus_rd = 1; bus_addr = ga(2,0); evt_in[64 +: 32] = 32'h1;
      exp_q.push_back(32'h1); tag_q.push_back("R10 cor collision read");
      @(negedge clk); bus_rd = 0; evt_in = '0;
      do_rd(ga(2,0), 32'h1, "R10 cor collision kept");
      do_rd(ga(2,0), 32'h0, "R3 cor after collision");
      // R5 / R6 mask ports
      do_wr(ga(0,2), 32'hffffffff);
      do_wr(ga(0,1), 32'h000000f0);
      do_rd(ga(0,3), 32'h000000f0, "R5 mask set");
      do_wr(ga(0,2), 32'h00000030);
      do_rd(ga(0,3), 32'h000000c0, "R6 mask clear partial");
      // R12 unmapped
      do_wr(5'd30, 32'hdeadbeef);
      do_rd(5'd30, 32'h0, "R12 unmapped read");
      do_rd(25, 32'hffffffff, "R12 swmask untouched");
      // R9 misc path end to end
      do_wr(25, 32'hfffffff8);
      do_wr(ga(2,2), 32'h4);
      pulse(2, 32'h4);
      idle(3);
      chk({31'b0, irq}, 32'h1, "R9 misc irq");
      do_rd(24, 32'h4, "R8 pseudo misc");
      do_rd(ga(2,0), 32'h4, "R3 misc cor");
      do_rd(24, 32'h4, "R8 pseudo misc sticky");
      do_rd(24, 32'h0, "R8 pseudo misc cleared");
      idle(2);
      chk({31'b0, irq}, 32'h0, "R9 irq drops");
      idle(3);
      finish_run();
   end
endmodule